// File: doc/BRIEF.md
# Auto-slot I2S Receiver

This block receives a two-channel I2S stream as a target. The external controller drives the bit clock, the word clock and the serial data. The block samples all three with its own system clock and finds the rising edges of the bit clock. It takes the slot width from the data itself: it counts the bit clocks in each half of the word-clock period.

A 2-bit control selects how many bits to keep from each slot. Bits past that length are dropped. Positions that the slot does not reach are filled with zeros. The left and right samples come out together on two 32-bit buses, left-justified, with a one-cycle strobe.

The measured slot width is reported as well. A new width is accepted only when two consecutive slot measurements agree. A flag shows when the ratio is changing or has not yet settled.

Top module: `i2s_autoslot_rx`

## Requirements
- R1: `slot_o` takes a measured slot width (bit clocks per word-clock half) only when that measurement equals the one taken just before it. When it does, `unstable_o` drops to 0.
- R2: A slot measurement that differs from the previous one sets `unstable_o` to 1 and leaves `slot_o` at its last accepted value.
- R3: `wlen_i` encodes the word length as 00 = 16, 01 = 20, 10 = 24 and 11 = 32 bits.
- R4: When the slot is longer than the word length, only the first word-length bits of the slot are kept. Later bits in that slot never reach the outputs.
- R5: When the slot is shorter than the word length, the bit positions the slot does not supply read as zero. For example, a 24-bit slot with word length 32 gives zeros in output bits 7..0.
- R6: Data is sampled on rising bit-clock edges. The MSB of a slot is the bit one bit clock after the word-clock transition. Word clock low carries the left channel and high carries the right channel.
- R7: Each captured sample is left-justified on a 32-bit bus: slot bit k (counting from 0 at the MSB) lands on bus bit 31-k. All bus bits below the captured ones are zero.
- R8: `valid_o` pulses for exactly one cycle after a right slot completes. `left_o` and `right_o` update together in that cycle and hold their values otherwise. Each emitted pair needs a complete left slot followed by its right slot.
- R9: While `rst` is high, and after it is released, the outputs read: `valid_o` 0, `left_o` 0, `right_o` 0, `slot_o` 0, `unstable_o` 1. The partial frame that follows reset yields no output pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock from the external controller |
| ws_i | input | 1 | Word clock (low = left, high = right) |
| sd_i | input | 1 | Serial data, MSB first |
| wlen_i | input | 2 | Word length select: 00=16, 01=20, 10=24, 11=32 |
| left_o | output | 32 | Left sample, left-justified |
| right_o | output | 32 | Right sample, left-justified |
| valid_o | output | 1 | One-cycle strobe when a new sample pair is presented |
| slot_o | output | 7 | Accepted slot width in bit clocks |
| unstable_o | output | 1 | Slot width not yet confirmed, or changing |

## Verification
A bit counter that is off by one shifts every captured word by one position. The next sample pair then comes out scaled by two or halved, so the error shows within one frame. A wrong channel latch swaps or duplicates the two samples in the next pair. A broken agreement filter shows as a `slot_o` that follows a single odd slot, or as an `unstable_o` that stays high. Either is visible two slot measurements after the disturbance.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  // Word-length select codes
  typedef enum logic [1:0] {
    WL16 = 2'b00,
    WL20 = 2'b01,
    WL24 = 2'b10,
    WL32 = 2'b11
  } wlen_e;

  function automatic int unsigned word_bits(input logic [1:0] sel);
    case (sel)
      WL16:    word_bits = 16;
      WL20:    word_bits = 20;
      WL24:    word_bits = 24;
      default: word_bits = 32;
    endcase
  endfunction

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2s_slot_meter.sv
module i2s_slot_meter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             ws,
  output logic             start_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o,
  output logic             done_chan_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             unstable_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             ws_p, ws_q, synced;
  logic [CNT_W-1:0] cnt, prev_meas, meas;

  // Data at a rise belongs to the word-clock value seen one rise earlier
  always_comb begin
    start_o     = rise && (ws_p != ws_q);
    meas        = (cnt == CMAX) ? CMAX : CNT_W'(cnt + 1'b1);
    idx_o       = start_o ? '0 : meas;
    done_o      = start_o && synced;
    done_chan_o = ws_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_p       <= 1'b0;
      ws_q       <= 1'b0;
      synced     <= 1'b0;
      cnt        <= '0;
      prev_meas  <= '0;
      slot_o     <= '0;
      unstable_o <= 1'b1;
    end else if (rise) begin
      ws_q <= ws_p;
      ws_p <= ws;
      cnt  <= idx_o;
      if (start_o) begin
        synced <= 1'b1;
        if (synced) begin
          prev_meas <= meas;
          if (meas == prev_meas) begin
            slot_o     <= meas;
            unstable_o <= 1'b0;
          end else begin
            unstable_o <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2s_slot_capture.sv
module i2s_slot_capture
  import i2s_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              sd,
  input  logic              start,
  input  logic [CNT_W-1:0]  idx,
  input  logic [1:0]        wlen,
  input  logic              done,
  input  logic              done_chan,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);

  localparam int IW = $clog2(DATA_W);
  localparam logic [IW-1:0] TOP = IW'(DATA_W - 1);

  logic [DATA_W-1:0] acc, acc_n, left_hold;
  logic              have_left, take;

  always_comb begin
    take  = (int'(idx) < int'(word_bits(wlen))) && (int'(idx) < DATA_W);
    acc_n = start ? '0 : acc;
    if (take) acc_n[TOP - idx[IW-1:0]] = sd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise) begin
        acc <= acc_n;
        if (done) begin
          if (done_chan) begin
            if (have_left) begin
              left_o  <= left_hold;
              right_o <= acc;
              valid_o <= 1'b1;
            end
            have_left <= 1'b0;
          end else begin
            left_hold <= acc;
            have_left <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2s_autoslot_rx.sv
module i2s_autoslot_rx #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        wlen_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic              unstable_o
);

  logic [2:0]       pins_s;
  logic             bclk_d, bclk_rise;
  logic             start_w, done_w, done_chan_w;
  logic [CNT_W-1:0] idx_w;

  i2s_rx_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({bclk_i, ws_i, sd_i}),
    .dout (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= pins_s[2];
  end

  assign bclk_rise = pins_s[2] & ~bclk_d;

  i2s_slot_meter #(.CNT_W(CNT_W)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .rise        (bclk_rise),
    .ws          (pins_s[1]),
    .start_o     (start_w),
    .idx_o       (idx_w),
    .done_o      (done_w),
    .done_chan_o (done_chan_w),
    .slot_o      (slot_o),
    .unstable_o  (unstable_o)
  );

  i2s_slot_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .rise      (bclk_rise),
    .sd        (pins_s[0]),
    .start     (start_w),
    .idx       (idx_w),
    .wlen      (wlen_i),
    .done      (done_w),
    .done_chan (done_chan_w),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

endmodule

// File: rtl/i2s_autoslot_rx_chk.sv
module i2s_autoslot_rx_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              rise,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic [CNT_W-1:0]  slot_o,
  input logic              unstable_o
);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_valid_after_rise_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(rise));

  assert_pair_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_slot_commit_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot_o) |-> !unstable_o);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!valid_o && unstable_o && slot_o == '0));

endmodule

bind i2s_autoslot_rx i2s_autoslot_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rise       (bclk_rise),
  .valid_o    (valid_o),
  .left_o     (left_o),
  .right_o    (right_o),
  .slot_o     (slot_o),
  .unstable_o (unstable_o)
);

// File: tb/i2s_autoslot_rx_test.sv
`timescale 1ns/1ps
module i2s_autoslot_rx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [1:0]  wlen_i = 2'b10;
  logic [31:0] left_o, right_o;
  logic        valid_o, unstable_o;
  logic [6:0]  slot_o;

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_l [256];
  logic [31:0] exp_r [256];
  int wr = 0, rd = 0;
  string phase = "R9";

  always #2.5 clk = ~clk;

  i2s_autoslot_rx uut (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .wlen_i(wlen_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .slot_o(slot_o), .unstable_o(unstable_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R3 encoding
  function automatic int wbits(input logic [1:0] sel);
    case (sel)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  // R4 R5 R7: left-justified, truncated or zero-filled
  function automatic logic [31:0] exp_word(input logic [63:0] v, input int s, input int w);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (i < w && i < s) r[31-i] = v[s-1-i];
    return r;
  endfunction

  task automatic bit_period(input logic ws, input logic sd);
    @(negedge clk);
    bclk_i = 1'b0; ws_i = ws; sd_i = sd;
    repeat (4) @(negedge clk);
    bclk_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R6: word clock switches on the LSB period, MSB follows one bit later
  task automatic send_frame(input int sl, input int sr, input logic [63:0] lv,
                            input logic [63:0] rv, input bit expect_it);
    if (expect_it) begin
      exp_l[wr] = exp_word(lv, sl, wbits(wlen_i));
      exp_r[wr] = exp_word(rv, sr, wbits(wlen_i));
      wr++;
    end
    for (int c = 0; c < 2; c++) begin
      int s = (c == 0) ? sl : sr;
      logic [63:0] v = (c == 0) ? lv : rv;
      for (int k = 0; k < s; k++)
        bit_period((k == s - 1) ? ~c[0] : c[0], v[s-1-k]);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Monitor: R6 R7 R8 pair comparison
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (rd >= wr) begin
        chk(1'b0, {phase, " R8 unexpected pair"}, left_o, 32'h0);
      end else begin
        chk(left_o  == exp_l[rd], {phase, " R6 left"},  left_o,  exp_l[rd]);
        chk(right_o == exp_r[rd], {phase, " R7 right"}, right_o, exp_r[rd]);
        rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", rd, wr);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int sizes [9] = '{16, 18, 20, 24, 25, 32, 40, 48, 64};
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    // R9 reset state
    chk(valid_o == 1'b0, "R9 valid", {31'b0, valid_o}, 32'd0);
    chk(left_o == 32'd0 && right_o == 32'd0, "R9 data", left_o | right_o, 32'd0);
    chk(slot_o == 7'd0, "R9 slot", {25'b0, slot_o}, 32'd0);
    chk(unstable_o == 1'b1, "R9 unstable", {31'b0, unstable_o}, 32'd1);
    @(negedge clk); rst = 1'b0;

    // Partial frame after reset: no pair (R9)
    wlen_i = 2'b11;
    send_frame(32, 32, rnd64(), rnd64(), 1'b0);
    phase = "R6";
    send_frame(32, 32, 64'h0000_0000_8000_0001, 64'h0000_0000_7FFF_FFFE, 1'b1);
    send_frame(32, 32, rnd64(), rnd64(), 1'b1);
    chk(slot_o == 7'd32, "R1 slot 32", {25'b0, slot_o}, 32'd32);
    chk(unstable_o == 1'b0, "R1 locked", {31'b0, unstable_o}, 32'd0);

    phase = "R4";
    wlen_i = 2'b00;
    send_frame(32, 32, 64'h0000_0000_ABCD_FFFF, 64'h0000_0000_1234_FFFF, 1'b1);
    send_frame(48, 48, rnd64(), rnd64(), 1'b1);

    phase = "R5";
    wlen_i = 2'b11;
    send_frame(16, 16, 64'hBEEF, 64'h8001, 1'b1);
    send_frame(24, 24, 64'hFF_FFFF, 64'h80_0001, 1'b1);

    phase = "R2";
    wlen_i = 2'b10;
    send_frame(24, 24, rnd64(), rnd64(), 1'b1);
    send_frame(24, 24, rnd64(), rnd64(), 1'b1);
    chk(slot_o == 7'd24 && !unstable_o, "R1 slot 24 locked", {24'b0, unstable_o, slot_o}, 32'd24);
    send_frame(24, 16, rnd64(), rnd64(), 1'b1);
    send_frame(24, 24, rnd64(), rnd64(), 1'b1);
    chk(unstable_o == 1'b1, "R2 unstable set", {31'b0, unstable_o}, 32'd1);
    chk(slot_o == 7'd24, "R2 slot held", {25'b0, slot_o}, 32'd24);

    phase = "R3";
    for (int w = 0; w < 4; w++) begin
      wlen_i = w[1:0];
      send_frame(32, 32, 64'hFFFF_FFFF, 64'hA5A5_A5A5, 1'b1);
    end

    phase = "R7";
    for (int n = 0; n < 60; n++) begin
      int s = sizes[$urandom_range(8, 0)];
      wlen_i = 2'($urandom_range(3, 0));
      send_frame(s, s, rnd64(), rnd64(), 1'b1);
    end
    send_frame(32, 32, rnd64(), rnd64(), 1'b0);
    repeat (20) @(negedge clk);
    chk(rd == wr, "R8 pair count", rd, wr);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule